// File: doc/BRIEF.md
# Boundary-Scan Instruction and Data-Register Path

This block sits behind a standard 16-state test access port state machine. The state machine itself is not part of the block. It receives the test clock, the serial test input and one strobe per decoded controller state. From these it keeps a 3-bit instruction register, made of a serial shift stage and a separately latched active instruction. It decodes the active instruction into a choice of test data register and a mode for the chip's output pins.

The block holds two data registers of its own: a 1-bit bypass register and a 32-bit identification register. The boundary-scan chain lives outside the block. It is reached through capture, shift and update enables, a serial input and a serial output. The test output is retimed on the falling edge of the test clock and has its own enable. The active instruction changes only on a falling edge, so the pin-mode controls never change in the middle of a data-register scan.

Top module: `jtag_scan_path`

## Requirements
- R1: A synchronous reset, or a cycle with the Test-Logic-Reset strobe high, makes IDCODE (001) the active instruction on that cycle's falling edge. The pin mode is then normal (00), and the identification register is the selected data register.
- R2: A Capture-IR cycle loads 001 into the instruction shift stage on the rising edge. Each Shift-IR cycle first presents stage bit 0 on `tdo` at the falling edge. It then shifts the stage one place toward bit 0 on the rising edge, and `tdi` enters bit 2.
- R3: The active instruction, and so `pin_mode`, changes only on the falling edge of an Update-IR cycle (or under R1). It holds through every Capture-IR, Shift-IR, Capture-DR, Shift-DR and Update-DR cycle.
- R4: Instruction codes and pin modes: EXTEST 000 gives drive-from-scan (01), CLAMP 011 gives clamp (10), HIGHZ 100 gives high-impedance (11). SAMPLE/PRELOAD 010, IDCODE 001, BYPASS 111 and the unused codes 101 and 110 give normal (00).
- R5: Under SAMPLE/PRELOAD and EXTEST, `bsr_capture`, `bsr_shift` and `bsr_update` follow the Capture-DR, Shift-DR and Update-DR strobes, and `tdo` in Shift-DR is `bsr_so` sampled at the falling edge. Under every other instruction, all three enables stay low. `bsr_si` carries `tdi`.
- R6: Under IDCODE, Capture-DR loads {version[3:0], part[15:0], manufacturer[10:0], 1'b1}. Shift-DR then sends it out least significant bit first, one bit per cycle.
- R7: Under BYPASS, CLAMP, HIGHZ, 101 and 110, the data path is one bit long. Capture-DR loads 0 into it, and in Shift-DR `tdo` repeats `tdi` from the previous shift cycle.
- R8: `tdo` and `tdo_oe` change only on falling edges. `tdo_oe` is 1 exactly in cycles that carry the Shift-IR or Shift-DR strobe, and `tdo` is 0 whenever `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial test data in |
| st_tlr | input | 1 | Controller is in Test-Logic-Reset |
| st_capture_ir | input | 1 | Controller is in Capture-IR |
| st_shift_ir | input | 1 | Controller is in Shift-IR |
| st_update_ir | input | 1 | Controller is in Update-IR |
| st_capture_dr | input | 1 | Controller is in Capture-DR |
| st_shift_dr | input | 1 | Controller is in Shift-DR |
| st_update_dr | input | 1 | Controller is in Update-DR |
| bsr_so | input | 1 | Serial output of the external boundary-scan chain |
| bsr_capture | output | 1 | Boundary-scan capture enable |
| bsr_shift | output | 1 | Boundary-scan shift enable |
| bsr_update | output | 1 | Boundary-scan update enable |
| bsr_si | output | 1 | Serial input to the boundary-scan chain |
| pin_mode | output | 2 | 00 normal, 01 drive-from-scan, 10 clamp, 11 high-impedance |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for `tdo` |

## Verification
Every defined code and both unused codes are loaded through full instruction scans, and a data scan follows each one. This separates the three data paths: the 32-bit code, a one-cycle echo of `tdi`, or the external chain's output. The data scans use irregular `tdi` and `bsr_so` patterns, so a pass-through path cannot be mistaken for a delayed one. Each instruction scan also reads out the captured 001, which exposes a wrong shift direction or a wrong capture value. A Test-Logic-Reset pulse taken while EXTEST is active shows the forced return to IDCODE and to normal pin mode.

// File: rtl/jtag_path_pkg.sv
package jtag_path_pkg;

    localparam int IR_W = 3;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 3'b000,
        OP_IDCODE = 3'b001,
        OP_SAMPLE = 3'b010,
        OP_CLAMP  = 3'b011,
        OP_HIGHZ  = 3'b100,
        OP_BYPASS = 3'b111
    } instr_e;

    localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 3'b001;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_DRIVE  = 2'b01,
        PM_CLAMP  = 2'b10,
        PM_HIGHZ  = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SEL_BSR = 2'b00,
        SEL_ID  = 2'b01,
        SEL_BYP = 2'b10
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e   sel;
        pin_mode_e mode;
    } decode_t;

    typedef struct packed {
        logic tlr;
        logic cap_ir;
        logic shf_ir;
        logic upd_ir;
        logic cap_dr;
        logic shf_dr;
        logic upd_dr;
    } tap_strobe_t;

    function automatic decode_t decode_instr(logic [IR_W-1:0] code);
        decode_t d;
        d.sel  = SEL_BYP;
        d.mode = PM_NORMAL;
        case (code)
            OP_EXTEST: begin d.sel = SEL_BSR; d.mode = PM_DRIVE; end
            OP_SAMPLE: d.sel = SEL_BSR;
            OP_IDCODE: d.sel = SEL_ID;
            OP_CLAMP:  d.mode = PM_CLAMP;
            OP_HIGHZ:  d.mode = PM_HIGHZ;
            default:   d.sel = SEL_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/jtag_ir_stage.sv
module jtag_ir_stage
    import jtag_path_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_strobe_t     stb,
    output logic            sr_lsb,
    output logic [IR_W-1:0] active
);
    logic [IR_W-1:0] shift_q;

    always_ff @(posedge tck) begin
        if (rst || stb.cap_ir) begin
            shift_q <= IR_CAPTURE_VAL;
        end else if (stb.shf_ir) begin
            shift_q <= {tdi, shift_q[IR_W-1:1]};
        end
    end

    always_ff @(negedge tck) begin
        if (rst || stb.tlr) begin
            active <= OP_IDCODE;
        end else if (stb.upd_ir) begin
            active <= shift_q;
        end
    end

    assign sr_lsb = shift_q[0];
endmodule

// File: rtl/jtag_data_regs.sv
module jtag_data_regs
    import jtag_path_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h0001,
    parameter logic [10:0] ID_MANUF   = 11'h001
) (
    input  logic    tck,
    input  logic    rst,
    input  logic    tdi,
    input  dr_sel_e sel,
    input  logic    capture,
    input  logic    shift,
    output logic    byp_bit,
    output logic    id_bit
);
    localparam int          ID_W     = 32;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MANUF, 1'b1};

    logic            byp_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= ID_VALUE;
        end else begin
            if (sel == SEL_BYP) begin
                if (capture)    byp_q <= 1'b0;
                else if (shift) byp_q <= tdi;
            end
            if (sel == SEL_ID) begin
                if (capture)    id_q <= ID_VALUE;
                else if (shift) id_q <= {tdi, id_q[ID_W-1:1]};
            end
        end
    end

    assign byp_bit = byp_q;
    assign id_bit  = id_q[0];
endmodule

// File: rtl/jtag_tdo_mux.sv
module jtag_tdo_mux
    import jtag_path_pkg::*;
(
    input  logic    tck,
    input  logic    rst,
    input  logic    shf_ir,
    input  logic    shf_dr,
    input  dr_sel_e sel,
    input  logic    ir_bit,
    input  logic    byp_bit,
    input  logic    id_bit,
    input  logic    bsr_bit,
    output logic    tdo,
    output logic    tdo_oe
);
    logic dr_bit;

    always_comb begin
        case (sel)
            SEL_BSR: dr_bit = bsr_bit;
            SEL_ID:  dr_bit = id_bit;
            default: dr_bit = byp_bit;
        endcase
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shf_ir || shf_dr;
            if (shf_ir)      tdo <= ir_bit;
            else if (shf_dr) tdo <= dr_bit;
            else             tdo <= 1'b0;
        end
    end
endmodule

// File: rtl/jtag_scan_path.sv
module jtag_scan_path
    import jtag_path_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [15:0] ID_PART    = 16'h0001,
    parameter logic [10:0] ID_MANUF   = 11'h001
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  logic       st_tlr,
    input  logic       st_capture_ir,
    input  logic       st_shift_ir,
    input  logic       st_update_ir,
    input  logic       st_capture_dr,
    input  logic       st_shift_dr,
    input  logic       st_update_dr,
    input  logic       bsr_so,
    output logic       bsr_capture,
    output logic       bsr_shift,
    output logic       bsr_update,
    output logic       bsr_si,
    output logic [1:0] pin_mode,
    output logic       tdo,
    output logic       tdo_oe
);
    tap_strobe_t     stb;
    logic [IR_W-1:0] active;
    logic            ir_bit;
    logic            byp_bit;
    logic            id_bit;
    decode_t         dec;
    logic            bsr_sel;

    assign stb = '{tlr: st_tlr, cap_ir: st_capture_ir, shf_ir: st_shift_ir,
                   upd_ir: st_update_ir, cap_dr: st_capture_dr,
                   shf_dr: st_shift_dr, upd_dr: st_update_dr};

    jtag_ir_stage i_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .stb    (stb),
        .sr_lsb (ir_bit),
        .active (active)
    );

    assign dec     = decode_instr(active);
    assign bsr_sel = (dec.sel == SEL_BSR);

    jtag_data_regs #(
        .ID_VERSION (ID_VERSION),
        .ID_PART    (ID_PART),
        .ID_MANUF   (ID_MANUF)
    ) i_dr (
        .tck     (tck),
        .rst     (rst),
        .tdi     (tdi),
        .sel     (dec.sel),
        .capture (stb.cap_dr),
        .shift   (stb.shf_dr),
        .byp_bit (byp_bit),
        .id_bit  (id_bit)
    );

    jtag_tdo_mux i_tdo (
        .tck     (tck),
        .rst     (rst),
        .shf_ir  (stb.shf_ir),
        .shf_dr  (stb.shf_dr),
        .sel     (dec.sel),
        .ir_bit  (ir_bit),
        .byp_bit (byp_bit),
        .id_bit  (id_bit),
        .bsr_bit (bsr_so),
        .tdo     (tdo),
        .tdo_oe  (tdo_oe)
    );

    assign bsr_capture = bsr_sel && stb.cap_dr;
    assign bsr_shift   = bsr_sel && stb.shf_dr;
    assign bsr_update  = bsr_sel && stb.upd_dr;
    assign bsr_si      = tdi;
    assign pin_mode    = dec.mode;
endmodule

// File: rtl/jtag_scan_path_chk.sv
module jtag_scan_path_chk (
    input logic       tck,
    input logic       rst,
    input logic       st_tlr,
    input logic       st_update_ir,
    input logic       st_shift_ir,
    input logic       st_shift_dr,
    input logic       bsr_capture,
    input logic       bsr_shift,
    input logic       bsr_update,
    input logic [1:0] pin_mode,
    input logic       tdo,
    input logic       tdo_oe
);
    // R1: a reset strobe leaves the pins in normal mode
    p_tlr_normal_r1: assert property (@(posedge tck) disable iff (rst)
        st_tlr |-> pin_mode == 2'b00);

    // R3: pin mode moves only in an instruction update or reset cycle
    p_mode_hold_r3: assert property (@(posedge tck) disable iff (rst)
        !$stable(pin_mode) |-> (st_update_ir || st_tlr));

    // R5: at most one chain enable at a time
    p_bsr_onehot_r5: assert property (@(posedge tck) disable iff (rst)
        $onehot0({bsr_capture, bsr_shift, bsr_update}));

    // R5: the chain shifts only under an instruction that leaves pins normal or driven
    p_bsr_mode_r5: assert property (@(posedge tck) disable iff (rst)
        bsr_shift |-> (pin_mode == 2'b00 || pin_mode == 2'b01));

    // R8: output enable only inside a shift state
    p_oe_shift_r8: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (st_shift_ir || st_shift_dr));

    // R8: quiet output when disabled
    p_tdo_quiet_r8: assert property (@(posedge tck) disable iff (rst)
        !tdo_oe |-> !tdo);
endmodule

bind jtag_scan_path jtag_scan_path_chk i_chk (
    .tck          (tck),
    .rst          (rst),
    .st_tlr       (st_tlr),
    .st_update_ir (st_update_ir),
    .st_shift_ir  (st_shift_ir),
    .st_shift_dr  (st_shift_dr),
    .bsr_capture  (bsr_capture),
    .bsr_shift    (bsr_shift),
    .bsr_update   (bsr_update),
    .pin_mode     (pin_mode),
    .tdo          (tdo),
    .tdo_oe       (tdo_oe)
);

// File: tb/test_jtag_scan_path.sv
`timescale 1ns/1ps
module test_jtag_scan_path;
    localparam logic [3:0]  VER  = 4'hA;
    localparam logic [15:0] PART = 16'h5A3C;
    localparam logic [10:0] MAN  = 11'h2B5;
    localparam logic [31:0] IDV  = {VER, PART, MAN, 1'b1};

    localparam bit [6:0] S_NONE = 7'b0000000;
    localparam bit [6:0] S_TLR  = 7'b1000000;
    localparam bit [6:0] S_CIR  = 7'b0100000;
    localparam bit [6:0] S_SIR  = 7'b0010000;
    localparam bit [6:0] S_UIR  = 7'b0001000;
    localparam bit [6:0] S_CDR  = 7'b0000100;
    localparam bit [6:0] S_SDR  = 7'b0000010;
    localparam bit [6:0] S_UDR  = 7'b0000001;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tdi = 1'b0;
    logic st_tlr = 0, st_capture_ir = 0, st_shift_ir = 0, st_update_ir = 0;
    logic st_capture_dr = 0, st_shift_dr = 0, st_update_dr = 0;
    logic bsr_so = 1'b0;
    logic bsr_capture, bsr_shift, bsr_update, bsr_si, tdo, tdo_oe;
    logic [1:0] pin_mode;

    always #2.5 tck = ~tck;

    jtag_scan_path #(.ID_VERSION(VER), .ID_PART(PART), .ID_MANUF(MAN)) i_jtag_scan_path (
        .tck(tck), .rst(rst), .tdi(tdi),
        .st_tlr(st_tlr), .st_capture_ir(st_capture_ir), .st_shift_ir(st_shift_ir),
        .st_update_ir(st_update_ir), .st_capture_dr(st_capture_dr),
        .st_shift_dr(st_shift_dr), .st_update_dr(st_update_dr),
        .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
        .bsr_update(bsr_update), .bsr_si(bsr_si), .pin_mode(pin_mode),
        .tdo(tdo), .tdo_oe(tdo_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_instr = 1;
    bit ir_q[$];
    bit dr_q[$];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int mode_of(int code);
        case (code)
            0: return 1;
            3: return 2;
            4: return 3;
            default: return 0;
        endcase
    endfunction

    // 0 chain, 1 identification, 2 bypass
    function automatic int sel_of(int code);
        case (code)
            0, 2: return 0;
            1: return 1;
            default: return 2;
        endcase
    endfunction

    task automatic load_id_q();
        dr_q.delete();
        for (int i = 0; i < 32; i++) dr_q.push_back(IDV[i]);
    endtask

    task automatic reset_ir_q();
        ir_q.delete();
        ir_q.push_back(1'b1); ir_q.push_back(1'b0); ir_q.push_back(1'b0);
    endtask

    task automatic cyc(input bit [6:0] s, input bit t, input bit so);
        int exp_tdo, sel;
        string ttag;
        {st_tlr, st_capture_ir, st_shift_ir, st_update_ir,
         st_capture_dr, st_shift_dr, st_update_dr} = s;
        tdi = t;
        bsr_so = so;
        @(negedge tck); #1;
        if (rst || s[6]) m_instr = 1;
        else if (s[3]) m_instr = {ir_q[2], ir_q[1], ir_q[0]};
        sel = sel_of(m_instr);
        ttag = "R8";
        exp_tdo = 0;
        if (!rst && s[4]) begin
            exp_tdo = ir_q[0]; ttag = "R2";
        end else if (!rst && s[1]) begin
            if (sel == 0)      begin exp_tdo = so;      ttag = "R5"; end
            else if (sel == 1) begin exp_tdo = dr_q[0]; ttag = "R6"; end
            else               begin exp_tdo = dr_q[0]; ttag = "R7"; end
        end
        if (rst || s[6])  chk("R1", "pin_mode", pin_mode, mode_of(m_instr));
        else if (s[3])    chk("R4", "pin_mode", pin_mode, mode_of(m_instr));
        else              chk("R3", "pin_mode", pin_mode, mode_of(m_instr));
        chk("R8", "tdo_oe", tdo_oe, (!rst && (s[4] || s[1])) ? 1 : 0);
        chk(ttag, "tdo", tdo, exp_tdo);
        chk("R5", "bsr_capture", bsr_capture, (sel == 0 && s[2]) ? 1 : 0);
        chk("R5", "bsr_shift",   bsr_shift,   (sel == 0 && s[1]) ? 1 : 0);
        chk("R5", "bsr_update",  bsr_update,  (sel == 0 && s[0]) ? 1 : 0);
        chk("R5", "bsr_si",      bsr_si,      t);
        @(posedge tck); #1;
        if (rst) begin
            reset_ir_q();
            load_id_q();
        end else begin
            if (s[5]) reset_ir_q();
            else if (s[4]) begin void'(ir_q.pop_front()); ir_q.push_back(t); end
            if (s[2] && sel == 1) load_id_q();
            else if (s[2] && sel == 2) begin dr_q.delete(); dr_q.push_back(1'b0); end
            else if (s[1] && sel != 0) begin void'(dr_q.pop_front()); dr_q.push_back(t); end
        end
    endtask

    task automatic ir_scan(input bit [2:0] code);
        cyc(S_CIR, 0, 0);
        for (int i = 0; i < 3; i++) cyc(S_SIR, code[i], 0);
        cyc(S_NONE, 0, 0);
        cyc(S_UIR, 0, 0);
    endtask

    task automatic dr_scan(input int n, input bit [31:0] pat);
        cyc(S_CDR, 0, 0);
        for (int i = 0; i < n; i++) cyc(S_SDR, pat[i], ~pat[(i + 5) % 32]);
        cyc(S_NONE, 0, 0);
        cyc(S_UDR, 0, 0);
    endtask

    initial begin
        reset_ir_q();
        load_id_q();
        rst = 1'b1;
        cyc(S_NONE, 0, 0);
        cyc(S_NONE, 0, 0);
        rst = 1'b0;
        cyc(S_NONE, 0, 0);
        chk("R1", "reset pin_mode", pin_mode, 0);
        dr_scan(32, 32'h0F0F_3C96);     // R6: code read out after reset
        dr_scan(34, 32'h1234_5678);     // R6: code then tdi echo
        ir_scan(3'b111);                // R2, R4: bypass
        dr_scan(12, 32'h0000_0B6D);     // R7
        ir_scan(3'b000);                // R4: EXTEST drive
        dr_scan(10, 32'h0000_02D3);     // R5
        cyc(S_TLR, 0, 0);               // R1: forced back to IDCODE
        chk("R1", "pin_mode after tlr", pin_mode, 0);
        dr_scan(8, 32'h0000_00A5);
        ir_scan(3'b010);                // R5: sample/preload
        dr_scan(9, 32'h0000_01C7);
        ir_scan(3'b011);                // R3, R4: clamp held across scan
        dr_scan(6, 32'h0000_0029);
        ir_scan(3'b100);                // R4: high-Z
        dr_scan(6, 32'h0000_0036);
        ir_scan(3'b101);                // R7: unused code
        dr_scan(5, 32'h0000_0015);
        ir_scan(3'b110);                // R7: unused code
        dr_scan(5, 32'h0000_000B);
        ir_scan(3'b001);                // R6: IDCODE by scan
        dr_scan(32, 32'hFFFF_0000);
        cyc(S_NONE, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule